// File: doc/BRIEF.md
# Unsigned Compressor-Tree Multiplier

This block multiplies two unsigned operands and returns the exact double-width product. Every multiplier bit gates a copy of the multiplicand. Each copy is shifted by that bit's position, and all rows are built at the same time with AND gates. The rows then pass through levels of (4,2) counters. Each level takes groups of four rows and turns each group into two rows, so eight rows become four and then two. A single carry-propagate addition turns the last two rows into the product.

Each (4,2) counter is two chained full adders. It takes four bits of one weight plus a lateral carry from the counter one column lower. It returns a sum bit at its own weight and two carries at the next weight. One of those carries is lateral: it goes to the neighbouring counter at the same level. That lateral carry-out depends only on the counter's first three inputs, so carries never ripple along a level. In the top column the carries would fall beyond the product width, so they are dropped and only the parity of the five bits is kept.

A parameter selects whether the product leaves through a register stage with an asynchronous active-low reset, which is the default, or leaves combinationally.

Top module: `cmpr_mult`

## Requirements
- R1: With the output register enabled, `prod` equals `op_a * op_b` (unsigned, 16 bits) as sampled at the previous rising clock edge. The operands are 8 bits wide.
- R2: When either operand sampled at the previous edge is zero, `prod` is zero.
- R3: `prod` never exceeds 0xFE01. Operands 0xFF and 0xFF give exactly 0xFE01.
- R4: For each of the 32 input patterns of a (4,2) counter, the value `sum + 2*(carry + cout)` equals the number of ones among x0, x1, x2, x3 and cin.
- R5: A counter's lateral carry-out `cout` is the same for cin=0 and cin=1 whenever x0..x3 are held fixed.
- R6: While `rst_n` is low, the registered `prod` is zero whatever the operands are, and it clears without waiting for a clock edge.
- R7: A multiplier of one returns the multiplicand. A multiplier of 2^k returns the multiplicand shifted left by k.
- R8: With the output register disabled, `prod` equals `op_a * op_b` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| op_a | input | 8 | Unsigned multiplicand |
| op_b | input | 8 | Unsigned multiplier |
| prod | output | 16 | Unsigned product |

## Verification
On every cycle, the assertions compare the output with the product of the operands from one edge earlier, or from the same cycle when the register is off. They also check the zero-operand result, the unit-multiplier result, the upper bound and the cleared output during reset. The bench alone shows the properties of the counter cell: its five-input counting identity and the fact that its lateral carry-out does not depend on its lateral carry-in. The bench also walks every one of the 65,536 operand pairs, so each padded zero input and the dropped top-column carries are exercised against the exact product.

// File: rtl/cmpr_mult_pkg.sv
package cmpr_mult_pkg;
    localparam int unsigned OP_W   = 8;
    localparam int unsigned PROD_W = 2 * OP_W;
    // number of (4,2) levels: OP_W rows halve per level down to two
    localparam int unsigned LEVELS = $clog2(OP_W) - 1;
    localparam logic [PROD_W-1:0] PROD_MAX = PROD_W'((2**OP_W - 1) * (2**OP_W - 1));

    typedef logic [PROD_W-1:0] prod_t;

    typedef struct packed {
        prod_t prod;
    } out_reg_t;
endpackage

// File: rtl/fa_cell.sv
module fa_cell (
    input  logic a,
    input  logic b,
    input  logic c,
    output logic s,
    output logic co
);
    assign s  = a ^ b ^ c;
    assign co = (a & b) | (a & c) | (b & c);
endmodule

// File: rtl/cmpr42_cell.sv
module cmpr42_cell (
    input  logic x0,
    input  logic x1,
    input  logic x2,
    input  logic x3,
    input  logic cin,
    output logic sum,
    output logic carry,
    output logic cout
);
    logic s_mid;

    // first full adder: lateral carry-out depends on x0..x2 only
    fa_cell u_fa_lo (.a(x0), .b(x1), .c(x2), .s(s_mid), .co(cout));
    // second full adder folds in the fourth bit and the lateral carry-in
    fa_cell u_fa_hi (.a(s_mid), .b(x3), .c(cin), .s(sum), .co(carry));
endmodule

// File: rtl/cmpr42_level.sv
module cmpr42_level #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] r0,
    input  logic [W-1:0] r1,
    input  logic [W-1:0] r2,
    input  logic [W-1:0] r3,
    output logic [W-1:0] s_row,
    output logic [W-1:0] c_row
);
    logic [W-2:0] lat;
    logic [W-2:0] cy;

    for (genvar i = 0; i < W; i++) begin : g_col
        if (i < W - 1) begin : g_cell
            logic cin_i;
            if (i == 0) begin : g_first
                assign cin_i = 1'b0;
            end else begin : g_chain
                assign cin_i = lat[i-1];
            end
            cmpr42_cell u_cell (
                .x0   (r0[i]),
                .x1   (r1[i]),
                .x2   (r2[i]),
                .x3   (r3[i]),
                .cin  (cin_i),
                .sum  (s_row[i]),
                .carry(cy[i]),
                .cout (lat[i])
            );
        end else begin : g_top
            // carries out of the top column fall beyond the product width
            assign s_row[i] = r0[i] ^ r1[i] ^ r2[i] ^ r3[i] ^ lat[i-1];
        end
    end

    assign c_row = {cy, 1'b0};
endmodule

// File: rtl/pp_array.sv
module pp_array #(
    parameter int unsigned N = 8
) (
    input  logic [N-1:0]   mcand,
    input  logic [N-1:0]   mplier,
    output logic [2*N-1:0] pp [N]
);
    localparam int unsigned PW = 2 * N;

    for (genvar j = 0; j < N; j++) begin : g_row
        assign pp[j] = PW'(mcand & {N{mplier[j]}}) << j;
    end
endmodule

// File: rtl/cmpr_mult.sv
module cmpr_mult
    import cmpr_mult_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OP_W-1:0]   op_a,
    input  logic [OP_W-1:0]   op_b,
    output logic [PROD_W-1:0] prod
);
    prod_t    pp [OP_W];
    prod_t    fin_s;
    prod_t    fin_c;
    out_reg_t out_d;

    pp_array #(.N(OP_W)) u_pp (
        .mcand (op_a),
        .mplier(op_b),
        .pp    (pp)
    );

    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
        localparam int unsigned RIN = OP_W >> l;
        prod_t rin  [RIN];
        prod_t rout [RIN/2];

        if (l == 0) begin : g_src_pp
            assign rin = pp;
        end else begin : g_src_prev
            assign rin = g_lvl[l-1].rout;
        end

        for (genvar g = 0; g < RIN / 4; g++) begin : g_grp
            cmpr42_level #(.W(PROD_W)) u_lvl (
                .r0   (rin[4*g]),
                .r1   (rin[4*g+1]),
                .r2   (rin[4*g+2]),
                .r3   (rin[4*g+3]),
                .s_row(rout[2*g]),
                .c_row(rout[2*g+1])
            );
        end
    end

    assign fin_s = g_lvl[LEVELS-1].rout[0];
    assign fin_c = g_lvl[LEVELS-1].rout[1];

    always_comb begin
        out_d      = '0;
        out_d.prod = fin_s + fin_c;
    end

    if (OUT_REG) begin : g_reg
        out_reg_t out_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                out_q <= '0;
            end else begin
                out_q <= out_d;
            end
        end
        assign prod = out_q.prod;
    end else begin : g_comb
        assign prod = out_d.prod;
    end
endmodule

// File: rtl/cmpr_mult_chk.sv
module cmpr_mult_chk
    import cmpr_mult_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [OP_W-1:0]   op_a,
    input logic [OP_W-1:0]   op_b,
    input logic [PROD_W-1:0] prod
);
    logic primed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) primed_q <= 1'b0;
        else        primed_q <= 1'b1;
    end

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        prod <= PROD_MAX);

    if (OUT_REG) begin : g_reg_chk
        a_r1_exact_product: assert property (@(posedge clk) disable iff (!rst_n)
            primed_q |-> prod == PROD_W'($past(op_a)) * PROD_W'($past(op_b)));

        a_r2_zero_operand: assert property (@(posedge clk) disable iff (!rst_n)
            (primed_q && $past(op_a == '0 || op_b == '0)) |-> prod == '0);

        a_r7_unit_multiplier: assert property (@(posedge clk) disable iff (!rst_n)
            (primed_q && $past(op_b == OP_W'(1))) |-> prod == PROD_W'($past(op_a)));

        a_r6_reset_clear: assert property (@(posedge clk)
            !rst_n |=> prod == '0);
    end else begin : g_comb_chk
        a_r8_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
            prod == PROD_W'(op_a) * PROD_W'(op_b));
    end
endmodule

bind cmpr_mult cmpr_mult_chk #(.OUT_REG(OUT_REG)) u_chk (.*);

// File: tb/sim_cmpr_mult.sv
module sim_cmpr_mult;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  op_a = 8'h00;
    logic [7:0]  op_b = 8'h00;
    logic [15:0] prod_r;
    logic [15:0] prod_c;

    logic x0 = 1'b0, x1 = 1'b0, x2 = 1'b0, x3 = 1'b0, cin = 1'b0;
    logic c_sum, c_carry, c_cout;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic        pend_v   = 1'b0;
    logic [15:0] pend_exp = 16'h0;
    string       pend_tag = "R1";

    always #4 clk = ~clk;

    cmpr_mult #(.OUT_REG(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .prod(prod_r)
    );

    cmpr_mult #(.OUT_REG(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .prod(prod_c)
    );

    cmpr42_cell u_cell (
        .x0(x0), .x1(x1), .x2(x2), .x3(x3), .cin(cin),
        .sum(c_sum), .carry(c_carry), .cout(c_cout)
    );

    function automatic logic [15:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
        return 16'(a) * 16'(b);
    endfunction

    function automatic string tag_of(input logic [7:0] a, input logic [7:0] b);
        if (a == 8'h00 || b == 8'h00)      return "R2";
        if (a == 8'hFF && b == 8'hFF)      return "R3";
        if ((b & (b - 8'h01)) == 8'h00)    return "R7";
        return "R1";
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one operand pair per cycle: checks the registered result of the
    // previous pair, then drives the new pair and checks the combinational copy
    task automatic step(input logic [7:0] a, input logic [7:0] b);
        @(negedge clk);
        if (pend_v) check(pend_tag, prod_r, pend_exp);
        op_a = a;
        op_b = b;
        #1;
        check("R8", prod_c, ref_mul(a, b));
        pend_exp = ref_mul(a, b);
        pend_tag = tag_of(a, b);
        pend_v   = 1'b1;
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    initial begin
        void'($urandom(32'd20231));

        // R6: reset holds the registered output at zero
        op_a = 8'hA5;
        op_b = 8'h3C;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R6", prod_r, 16'h0000);
        rst_n = 1'b1;

        // R4 and R5: the counter cell on its own, every pattern
        for (int p = 0; p < 32; p++) begin
            logic [4:0] v;
            logic       co0;
            int         ones;
            v = 5'(p);
            {cin, x3, x2, x1, x0} = v;
            #1;
            ones = $countones(v);
            check("R4", 16'(c_sum) + 16'd2 * (16'(c_carry) + 16'(c_cout)), 16'(ones));
            co0 = c_cout;
            cin = ~cin;
            #1;
            check("R5", 16'(c_cout), 16'(co0));
        end

        // directed corner cases
        step(8'hFF, 8'hFF);
        step(8'h00, 8'hFF);
        step(8'hFF, 8'h00);
        step(8'h5A, 8'h01);
        step(8'h81, 8'h80);
        step(8'h01, 8'h01);
        for (int k = 0; k < 8; k++) step(8'hB7, 8'(1 << k));

        // exhaustive sweep of every operand pair (R1, R2, R3, R7)
        for (int i = 0; i < 65536; i++) step(8'(i >> 8), 8'(i));

        // R6: asynchronous reset in the middle of traffic
        @(negedge clk);
        check(pend_tag, prod_r, pend_exp);
        pend_v = 1'b0;
        op_a = 8'hEE;
        op_b = 8'hDD;
        rst_n = 1'b0;
        #1;
        check("R6", prod_r, 16'h0000);
        @(negedge clk);
        check("R6", prod_r, 16'h0000);
        rst_n = 1'b1;

        // seeded random operands
        for (int i = 0; i < 2000; i++) step(8'($urandom), 8'($urandom));

        @(negedge clk);
        if (pend_v) check(pend_tag, prod_r, pend_exp);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #(8 * 190000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule